// File: doc/BRIEF.md
# Communication Debug Override Controller

This block sits between a host register port and the control pins of a device's communication ports: an upper and a lower daisy-chain link (each with a transmitter and a receiver enable), and a UART. In normal operation every control pin simply follows the hardware-default value presented at its input. A small register file lets the host store override settings for these pins. The overrides reach the pins only while an unlock register holds the key value 0xA5, and only for the groups whose own group-enable bit is set.

Two groups exist. The daisy group replaces the four link enables with stored bits. The UART group adds three controls. The first steers received or forwarded daisy-chain traffic onto the UART. The second forces the UART transmitter on, which a stack device needs because its transmitter is off by hardware default. The third drops the UART to the slow 250 kbps rate instead of 1 Mbps. Relocking returns every pin to hardware control and keeps the stored overrides. Writing the key again applies the stored overrides at once.

A read-only status word shows which groups are under user control, the live link and UART transmit enables, and the lock state. It can be read at any time.

Top module: `comm_debug_ctrl`

## Requirements
- R1: After reset the key register, both control registers and all override bits read 0, and every output follows its hardware-default input.
- R2: Debug mode is active only while the key register (address 0) holds exactly 0xA5. Any other written value, including near misses such as 0xA4, leaves debug mode. Status bit 7 shows the active state.
- R3: With debug active and the daisy group bit (control A, address 1, bit 0) set to 1, link transmit enable i follows control B (address 2) bit i and link receive enable i follows control B bit 2+i. Index 0 is the upper link and index 1 is the lower link.
- R4: With the daisy group bit at 0, the link enables follow their hardware inputs even while debug is active.
- R5: With debug active and the UART group bit (control A bit 1) set to 1, the mirror select output equals control A bit 2.
- R6: With the UART group active, the UART transmit enable is the hardware default ORed with control A bit 3, so a stack device (hardware default 0) can transmit.
- R7: With the UART group active, the slow-baud output (1 = 250 kbps, 0 = 1 Mbps) equals control A bit 4.
- R8: With the UART group bit at 0, or debug inactive, the mirror and slow-baud outputs are 0 and the UART transmit enable equals its hardware input, whatever control A bits 2 to 4 hold.
- R9: Control registers keep their contents across lock and unlock. Rewriting 0xA5 reapplies them without further writes.
- R10: The status word (address 3) reads as follows. Bit 0 is UART user control and bit 1 is daisy user control. Bits 3:2 are the effective link transmit enables and bits 5:4 the effective link receive enables. Bit 6 is the effective UART transmit enable and bit 7 is debug active. It changes in the same cycle as the outputs and can be read with debug inactive.
- R11: Writes to the status address are ignored. Reads of unmapped addresses return 0. Control register bits without a function read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| regWe | input | 1 | Register write strobe |
| regAddr | input | 4 | Register address for write and read |
| regWdata | input | 8 | Write data |
| regRdata | output | 8 | Combinational read data for regAddr |
| hwDaisyTxEn | input | 2 | Hardware-default link transmit enables (bit 0 upper, bit 1 lower) |
| hwDaisyRxEn | input | 2 | Hardware-default link receive enables |
| hwUartTxEn | input | 1 | Hardware-default UART transmit enable (0 on stack devices) |
| daisyTxEn | output | 2 | Effective link transmit enables |
| daisyRxEn | output | 2 | Effective link receive enables |
| uartTxEn | output | 1 | Effective UART transmit enable |
| uartMirrorSel | output | 1 | Route daisy-chain traffic onto the UART |
| uartBaudSlow | output | 1 | 1 selects 250 kbps, 0 selects 1 Mbps |

## Verification
The hardest case to reach from the ports is stored overrides that survive a relock and come back, because it needs a sequence of writes. The bench first programs both control registers while unlocked and checks that the overrides take effect. It then writes a near-miss key and checks that every pin returns to its hardware value while the control registers still read back unchanged. Finally it rewrites 0xA5 alone and checks that the old overrides reappear. The hardware defaults are set opposite to the override bits, so a pin that stays stuck on either source shows up as a mismatch.

// File: rtl/cdbg_pkg.sv
package cdbg_pkg;
  // Strobes from the control side to the datapath
  typedef struct packed {
    logic wrKey;
    logic wrCtrlA;
    logic wrCtrlB;
    logic unlocked;
  } cdbgStrobe_t;

  // Control A field positions
  localparam int BIT_DAISY_GRP = 0;
  localparam int BIT_UART_GRP  = 1;
  localparam int BIT_MIRROR    = 2;
  localparam int BIT_UART_TX   = 3;
  localparam int BIT_BAUD_SLOW = 4;
  localparam int CTRLA_W       = 5;
endpackage

// File: rtl/cdbg_ctrl.sv
module cdbg_ctrl
  import cdbg_pkg::*;
#(
  parameter int ADDR_W   = 4,
  parameter int DATA_W   = 8,
  parameter int KEY      = 8'hA5,
  parameter int ADDR_KEY = 0,
  parameter int ADDR_A   = 1,
  parameter int ADDR_B   = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWdata,
  output cdbgStrobe_t       strobe,
  output logic [DATA_W-1:0] keyVal
);
  localparam logic [DATA_W-1:0] KEY_V  = DATA_W'(KEY);
  localparam logic [ADDR_W-1:0] A_KEY  = ADDR_W'(ADDR_KEY);
  localparam logic [ADDR_W-1:0] A_CTLA = ADDR_W'(ADDR_A);
  localparam logic [ADDR_W-1:0] A_CTLB = ADDR_W'(ADDR_B);

  logic [DATA_W-1:0] keyReg;

  always_comb begin
    strobe.wrKey    = regWe && (regAddr == A_KEY);
    strobe.wrCtrlA  = regWe && (regAddr == A_CTLA);
    strobe.wrCtrlB  = regWe && (regAddr == A_CTLB);
    strobe.unlocked = (keyReg == KEY_V);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) keyReg <= '0;
    else if (strobe.wrKey) keyReg <= regWdata;
  end

  assign keyVal = keyReg;

  // R2: lock state follows the value last written to the key address
  a_r2_unlock_follows_key: assert property (@(posedge clk) disable iff (!rstN)
    (regWe && regAddr == A_KEY) |=> (strobe.unlocked == ($past(regWdata) == KEY_V)));

  // R2: the key only changes on a key write
  a_r2_key_hold: assert property (@(posedge clk) disable iff (!rstN)
    !(regWe && regAddr == A_KEY) |=> $stable(keyVal));

  // R11: at most one register is written per cycle
  a_r11_one_strobe: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.wrKey, strobe.wrCtrlA, strobe.wrCtrlB}));
endmodule

// File: rtl/cdbg_datapath.sv
module cdbg_datapath
  import cdbg_pkg::*;
#(
  parameter int NUM_LINKS = 2,
  parameter int ADDR_W    = 4,
  parameter int DATA_W    = 8,
  parameter int ADDR_KEY  = 0,
  parameter int ADDR_A    = 1,
  parameter int ADDR_B    = 2,
  parameter int ADDR_STAT = 3
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  cdbgStrobe_t          strobe,
  input  logic [DATA_W-1:0]    regWdata,
  input  logic [ADDR_W-1:0]    regAddr,
  input  logic [DATA_W-1:0]    keyVal,
  output logic [DATA_W-1:0]    regRdata,
  input  logic [NUM_LINKS-1:0] hwDaisyTxEn,
  input  logic [NUM_LINKS-1:0] hwDaisyRxEn,
  input  logic                 hwUartTxEn,
  output logic [NUM_LINKS-1:0] daisyTxEn,
  output logic [NUM_LINKS-1:0] daisyRxEn,
  output logic                 uartTxEn,
  output logic                 uartMirrorSel,
  output logic                 uartBaudSlow
);
  localparam int CTRLB_W = 2 * NUM_LINKS;
  localparam int STAT_W  = 4 + 2 * NUM_LINKS;

  logic [CTRLA_W-1:0] ctrlA;
  logic [CTRLB_W-1:0] ctrlB;
  logic daisyUser, uartUser;
  logic [STAT_W-1:0] statusWord;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlA <= '0;
      ctrlB <= '0;
    end else begin
      if (strobe.wrCtrlA) ctrlA <= regWdata[CTRLA_W-1:0];
      if (strobe.wrCtrlB) ctrlB <= regWdata[CTRLB_W-1:0];
    end
  end

  assign daisyUser = strobe.unlocked && ctrlA[BIT_DAISY_GRP];
  assign uartUser  = strobe.unlocked && ctrlA[BIT_UART_GRP];

  for (genvar g = 0; g < NUM_LINKS; g++) begin : gLink
    assign daisyTxEn[g] = daisyUser ? ctrlB[g]             : hwDaisyTxEn[g];
    assign daisyRxEn[g] = daisyUser ? ctrlB[NUM_LINKS + g] : hwDaisyRxEn[g];
  end

  assign uartTxEn      = hwUartTxEn | (uartUser & ctrlA[BIT_UART_TX]);
  assign uartMirrorSel = uartUser & ctrlA[BIT_MIRROR];
  assign uartBaudSlow  = uartUser & ctrlA[BIT_BAUD_SLOW];

  assign statusWord = {strobe.unlocked, uartTxEn, daisyRxEn, daisyTxEn, daisyUser, uartUser};

  always_comb begin
    regRdata = '0;
    case (regAddr)
      ADDR_W'(ADDR_KEY):  regRdata = keyVal;
      ADDR_W'(ADDR_A):    regRdata[CTRLA_W-1:0] = ctrlA;
      ADDR_W'(ADDR_B):    regRdata[CTRLB_W-1:0] = ctrlB;
      ADDR_W'(ADDR_STAT): regRdata[STAT_W-1:0]  = statusWord;
      default:            regRdata = '0;
    endcase
  end

  // R9: stored overrides change only on their own writes
  a_r9_ctrla_hold: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.wrCtrlA |=> $stable(ctrlA));
  a_r9_ctrlb_hold: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.wrCtrlB |=> $stable(ctrlB));

  // R8: without the UART group the UART pins are hardware-driven
  a_r8_uart_hw: assert property (@(posedge clk) disable iff (!rstN)
    !uartUser |-> (uartTxEn == hwUartTxEn && !uartMirrorSel && !uartBaudSlow));

  // R5: mirroring never happens while locked
  a_r5_mirror_locked: assert property (@(posedge clk) disable iff (!rstN)
    uartMirrorSel |-> strobe.unlocked);

  // R4: when locked the links follow hardware
  a_r4_links_hw: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.unlocked |-> (daisyTxEn == hwDaisyTxEn && daisyRxEn == hwDaisyRxEn));
endmodule

// File: rtl/comm_debug_ctrl.sv
module comm_debug_ctrl
  import cdbg_pkg::*;
#(
  parameter int NUM_LINKS = 2,
  parameter int ADDR_W    = 4,
  parameter int DATA_W    = 8,
  parameter int KEY       = 8'hA5
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 regWe,
  input  logic [ADDR_W-1:0]    regAddr,
  input  logic [DATA_W-1:0]    regWdata,
  output logic [DATA_W-1:0]    regRdata,
  input  logic [NUM_LINKS-1:0] hwDaisyTxEn,
  input  logic [NUM_LINKS-1:0] hwDaisyRxEn,
  input  logic                 hwUartTxEn,
  output logic [NUM_LINKS-1:0] daisyTxEn,
  output logic [NUM_LINKS-1:0] daisyRxEn,
  output logic                 uartTxEn,
  output logic                 uartMirrorSel,
  output logic                 uartBaudSlow
);
  localparam int ADDR_KEY  = 0;
  localparam int ADDR_A    = 1;
  localparam int ADDR_B    = 2;
  localparam int ADDR_STAT = 3;

  cdbgStrobe_t       strobe;
  logic [DATA_W-1:0] keyVal;

  cdbg_ctrl #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .KEY(KEY),
    .ADDR_KEY(ADDR_KEY), .ADDR_A(ADDR_A), .ADDR_B(ADDR_B)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr),
    .regWdata(regWdata), .strobe(strobe), .keyVal(keyVal)
  );

  cdbg_datapath #(
    .NUM_LINKS(NUM_LINKS), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .ADDR_KEY(ADDR_KEY), .ADDR_A(ADDR_A), .ADDR_B(ADDR_B), .ADDR_STAT(ADDR_STAT)
  ) uData (
    .clk(clk), .rstN(rstN), .strobe(strobe), .regWdata(regWdata),
    .regAddr(regAddr), .keyVal(keyVal), .regRdata(regRdata),
    .hwDaisyTxEn(hwDaisyTxEn), .hwDaisyRxEn(hwDaisyRxEn), .hwUartTxEn(hwUartTxEn),
    .daisyTxEn(daisyTxEn), .daisyRxEn(daisyRxEn), .uartTxEn(uartTxEn),
    .uartMirrorSel(uartMirrorSel), .uartBaudSlow(uartBaudSlow)
  );
endmodule

// File: tb/tb_comm_debug_ctrl.sv
`timescale 1ns/1ps
module tb_comm_debug_ctrl;
  logic clk = 0, rstN = 0;
  logic regWe = 0;
  logic [3:0] regAddr = 0;
  logic [7:0] regWdata = 0, regRdata;
  logic [1:0] hwDaisyTxEn = 2'b10, hwDaisyRxEn = 2'b01;
  logic hwUartTxEn = 0;
  logic [1:0] daisyTxEn, daisyRxEn;
  logic uartTxEn, uartMirrorSel, uartBaudSlow;
  int nTests = 0, nFail = 0;
  bit done = 0;

  always #5 clk = ~clk;

  comm_debug_ctrl dut (.*);

  task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
    nTests++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [7:0] d);
    @(negedge clk); regWe = 1; regAddr = a; regWdata = d;
    @(negedge clk); regWe = 0;
  endtask

  task automatic rd(logic [3:0] a, output logic [7:0] d);
    regAddr = a; #1; d = regRdata;
  endtask

  function automatic logic [7:0] expStat(logic unl, logic utx, logic [1:0] rx,
                                         logic [1:0] tx, logic du, logic uu);
    return {unl, utx, rx, tx, du, uu};
  endfunction

  task automatic t_reset();
    logic [7:0] d;
    rd(0, d); check("R1 key", d, 8'h00);
    rd(1, d); check("R1 ctrlA", d, 8'h00);
    rd(2, d); check("R1 ctrlB", d, 8'h00);
    check("R1 outputs", {daisyTxEn, daisyRxEn, uartTxEn, uartMirrorSel, uartBaudSlow},
          {hwDaisyTxEn, hwDaisyRxEn, hwUartTxEn, 2'b00});
    rd(3, d); check("R10 status locked", d, expStat(0, 0, 2'b01, 2'b10, 0, 0));
  endtask

  task automatic t_daisy();
    logic [7:0] d;
    wr(2, 8'h09);            // tx=01 rx=10 (opposite of hw)
    wr(1, 8'h01);            // daisy group only
    check("R2 locked stays hw", {daisyTxEn, daisyRxEn}, {2'b10, 2'b01});
    wr(0, 8'hA5);
    check("R3 tx override", daisyTxEn, 2'b01);
    check("R3 rx override", daisyRxEn, 2'b10);
    rd(3, d); check("R10 status daisy", d, expStat(1, 0, 2'b10, 2'b01, 1, 0));
    wr(1, 8'h00);
    check("R4 group off", {daisyTxEn, daisyRxEn}, {2'b10, 2'b01});
  endtask

  task automatic t_uart();
    logic [7:0] d;
    wr(1, 8'h1C);            // mirror, tx, baud set but group off
    check("R8 grp off", {uartTxEn, uartMirrorSel, uartBaudSlow}, 3'b000);
    wr(1, 8'h06);            // group + mirror
    check("R5 mirror", uartMirrorSel, 1);
    check("R6 tx stays hw", uartTxEn, 0);
    check("R7 baud fast", uartBaudSlow, 0);
    wr(1, 8'h1E);
    check("R6 tx forced", uartTxEn, 1);
    check("R7 baud slow", uartBaudSlow, 1);
    rd(3, d); check("R10 status uart", d, expStat(1, 1, 2'b01, 2'b10, 0, 1));
    hwUartTxEn = 1; wr(1, 8'h02);
    check("R6 base hw on", uartTxEn, 1);
    hwUartTxEn = 0;
  endtask

  task automatic t_relock();
    logic [7:0] d;
    wr(2, 8'h09); wr(1, 8'h1F);
    wr(0, 8'hA4);
    check("R2 near miss locks", {daisyTxEn, daisyRxEn, uartTxEn, uartMirrorSel, uartBaudSlow},
          {2'b10, 2'b01, 3'b000});
    rd(3, d); check("R2 status bit7", d[7], 0);
    rd(1, d); check("R9 ctrlA kept", d, 8'h1F);
    rd(2, d); check("R9 ctrlB kept", d, 8'h09);
    wr(0, 8'hA5);
    check("R9 reapplied", {daisyTxEn, daisyRxEn, uartTxEn, uartMirrorSel, uartBaudSlow},
          {2'b01, 2'b10, 3'b111});
    rd(3, d); check("R10 status full", d, expStat(1, 1, 2'b10, 2'b01, 1, 1));
  endtask

  task automatic t_ro_unmapped();
    logic [7:0] d;
    wr(3, 8'h00);
    rd(3, d); check("R11 status write ignored", d, expStat(1, 1, 2'b10, 2'b01, 1, 1));
    rd(0, d); check("R11 key intact", d, 8'hA5);
    for (int a = 4; a < 16; a++) begin
      rd(a[3:0], d); check("R11 unmapped", d, 8'h00);
    end
    wr(1, 8'hFF); rd(1, d); check("R11 unused bits", d, 8'h1F);
    wr(0, 8'h00);
    check("R8 locked uart", {uartTxEn, uartMirrorSel, uartBaudSlow}, 3'b000);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    t_reset();
    t_daisy();
    t_uart();
    t_relock();
    t_ro_unmapped();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nTests++; nFail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end
endmodule